// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Port

This block is the device end of a three-wire, bit-serial register port for a real-time clock. A host drives an enable line, a serial clock and a data-in line. It reads back a data-out line and a ready flag. All host lines are sampled by the block's own system clock, so each serial clock half-period must last at least one system clock cycle. When idle, the host holds all three lines low. A transfer opens when the host raises enable while ready is high.

Each transfer carries a 4-bit address frame. Its top three bits pick one of eight 32-bit register slots, and its lowest bit gives the direction. A write sends the 32-bit data word first, then the address frame. A read sends the address frame first, then clocks 32 bits out. The host lowers enable just before the last address bit, and that bit closes the frame. Slot 0 is a seconds counter, advanced by a one-second tick input. Slot 1 is a 25-bit output-control word with these fields: count in bits 19:0, command in bits 21:20 (1 = immediate, 2 = after count, 3 = pulse), polarity in bit 22, busy in bit 23 and level in bit 24. The remaining slots are empty.

Top module: `rtc_serial_port`

## Requirements
- R1: With reset held low at a clock edge, the block returns to idle with ready = 1, data-out = 0, the seconds register = 0 and the control word = 0.
- R2: A rising edge of enable while ready is 1 opens a frame, and ready reads 0 from the next cycle on.
- R3: Data-in is taken on each rising serial-clock edge of an open frame. The last four bits taken form the address, most significant bit first: bits 3:1 select the slot and bit 0 is the direction (1 = write, 0 = read).
- R4: A frame stays open while enable is high. The first rising serial-clock edge with enable low supplies the final bit and closes the frame.
- R5: A write frame holds exactly 36 bits: 32 data bits MSB first, then the address. When it closes with direction 1, the data commits to the selected slot and ready returns to 1.
- R6: A read frame loads the selected slot's value as it stands when the frame closes. On each of the next 32 serial-clock pulses, data-out changes on the falling edge and presents one bit, MSB first. Ready returns to 1 after the 32nd bit.
- R7: The seconds register (slot 0) increases by one in every cycle where the tick input is high and no write to slot 0 commits.
- R8: When a write to slot 0 commits in the same cycle as a tick, the register takes the written value and the tick is lost.
- R9: Slot 1 stores bits 24:0 of a written word and shows them on the control-word output. Bits 31:25 read back as zero. The control word changes only when a write to slot 1 commits.
- R10: Slots 2 to 7 read as zero. Writes to them change no register.
- R11: A frame that closes after fewer than 4 bits is discarded. No register changes, and ready returns to 1.
- R12: A frame that ends with direction 1 but does not hold exactly 36 bits is discarded, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ser_en | input | 1 | Host frame enable |
| ser_clk | input | 1 | Host serial clock |
| ser_din | input | 1 | Host serial data into the block |
| ser_dout | output | 1 | Serial data to the host |
| ser_ready | output | 1 | High when a new frame may start |
| seconds_o | output | 32 | Current seconds register |
| gpo_word_o | output | 25 | Current output-control word |

## Verification
The hardest cases to reach are a frame closing in the same cycle as a tick, and frames whose length is wrong. The stimulus raises the tick on exactly the system-clock cycle in which the closing rising edge is seen. It also sends frames of 3 bits, 5 bits and 35 bits, and one frame that keeps enable high past the four address bits. A behavioural model built on a bit queue follows every cycle. Directed checks against constants taken from the requirements back it up.

// File: rtl/rtc_ser_pkg.sv
// Shared constants and types for the serial RTC register port.
// Assumes one fixed frame layout: data word followed by the address nibble.
package rtc_ser_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned GPO_W   = 25;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_SEND = 2'd2
    } phase_e;
endpackage

// File: rtl/rtc_ser_edge.sv
// Edge detector for the host enable and serial clock lines.
// Assumes the host lines are already synchronous to clk; one register stage
// per line supplies the previous value used for edge detection.
module rtc_ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic en,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic en_rise
);
    logic sclk_q;
    logic en_q;

    // Keep last cycle's value of each host line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            en_q   <= en;
        end
    end

    // Edge flags are true in the first cycle a new level is seen.
    always_comb begin
        sclk_rise = sclk & ~sclk_q;
        sclk_fall = ~sclk & sclk_q;
        en_rise   = en & ~en_q;
    end
endmodule

// File: rtl/rtc_ser_frame.sv
// Frame engine: collects serial bits, decodes the closing address nibble,
// issues a one-cycle write strobe or loads a read word and shifts it out.
// Assumes the frame closes on the first serial rising edge seen with enable low.
module rtc_ser_frame
    import rtc_ser_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          en_rise,
    input  logic          en,
    input  logic          din,
    input  logic [DW-1:0] rd_data,
    output logic [AW-2:0] rd_sel,
    output logic          wr_stb,
    output logic [AW-2:0] wr_sel,
    output logic [DW-1:0] wr_data,
    output logic          dout,
    output logic          ready
);
    localparam int unsigned FW    = DW + AW;
    localparam int unsigned CNT_W = $clog2(FW + 1) + 1;
    localparam int unsigned TXC_W = $clog2(DW);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(AW);
    localparam logic [TXC_W-1:0] TX_LAST  = TXC_W'(DW - 1);

    phase_e           phase;
    logic [FW-1:0]    shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    tx_word;
    logic [TXC_W-1:0] tx_cnt;
    logic             tx_armed;

    logic [FW-1:0]    shreg_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             closing;
    logic             long_enough;
    logic             is_write;

    // Next shift state and the close decode for the current rising edge.
    always_comb begin
        shreg_nx    = {shreg[FW-2:0], din};
        cnt_nx      = (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + 1'b1;
        closing     = (phase == PH_RECV) && sclk_rise && !en;
        long_enough = (cnt_nx >= CNT_ADDR);
        is_write    = shreg_nx[0];
        wr_stb      = closing && long_enough && is_write && (cnt_nx == CNT_FULL);
        wr_sel      = shreg_nx[AW-1:1];
        wr_data     = shreg_nx[FW-1:AW];
        rd_sel      = shreg_nx[AW-1:1];
        ready       = (phase == PH_IDLE);
    end

    // Phase sequencing, bit collection and outbound shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            tx_word  <= '0;
            tx_cnt   <= '0;
            tx_armed <= 1'b0;
            dout     <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (en_rise) begin
                        phase   <= PH_RECV;
                        shreg   <= '0;
                        bit_cnt <= '0;
                    end
                end
                PH_RECV: begin
                    if (sclk_rise) begin
                        shreg   <= shreg_nx;
                        bit_cnt <= cnt_nx;
                        if (!en) begin
                            if (long_enough && !is_write) begin
                                phase    <= PH_SEND;
                                tx_word  <= rd_data;
                                tx_cnt   <= '0;
                                tx_armed <= 1'b0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                end
                PH_SEND: begin
                    if (sclk_rise) begin
                        tx_armed <= 1'b1;
                    end else if (sclk_fall && tx_armed) begin
                        dout     <= tx_word[DW-1];
                        tx_word  <= {tx_word[DW-2:0], 1'b0};
                        tx_armed <= 1'b0;
                        tx_cnt   <= tx_cnt + 1'b1;
                        if (tx_cnt == TX_LAST) phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rtc_ser_regs.sv
// Register slots behind the serial port: slot 0 seconds counter, slot 1
// output-control word, other slots empty. Writes arrive as one-cycle strobes.
// Assumes at most one write strobe per cycle; a write beats a tick.
module rtc_ser_regs
    import rtc_ser_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned SW = ADDR_W - 1,
    parameter int unsigned GW = GPO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_stb,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] seconds,
    output logic [GW-1:0] gpo_word
);
    localparam int unsigned SLOTS = 1 << SW;

    logic [DW-1:0] slot_view [SLOTS];

    // Seconds counter: a committed write wins over the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                          seconds <= '0;
        else if (wr_stb && wr_sel == '0)     seconds <= wr_data;
        else if (tick)                       seconds <= seconds + 1'b1;
    end

    // Output-control word: holds the low GW bits of a write to slot 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                              gpo_word <= '0;
        else if (wr_stb && wr_sel == SW'(1))     gpo_word <= wr_data[GW-1:0];
    end

    // Read view of every slot; unused slots read as zero.
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            if (s == 0) begin : g_sec
                assign slot_view[s] = seconds;
            end else if (s == 1) begin : g_gpo
                assign slot_view[s] = {{(DW-GW){1'b0}}, gpo_word};
            end else begin : g_empty
                assign slot_view[s] = '0;
            end
        end
    endgenerate

    // Read mux for the selected slot.
    always_comb rd_data = slot_view[rd_sel];
endmodule

// File: rtl/rtc_serial_port.sv
// Top of the serial RTC register port: edge detection, frame engine and
// register slots. Assumes host lines are synchronous to clk.
module rtc_serial_port
    import rtc_ser_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned GW = GPO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1hz,
    input  logic          ser_en,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_ready,
    output logic [DW-1:0] seconds_o,
    output logic [GW-1:0] gpo_word_o
);
    localparam int unsigned SW = AW - 1;

    logic          sclk_rise;
    logic          sclk_fall;
    logic          en_rise;
    logic [SW-1:0] rd_sel;
    logic [DW-1:0] rd_data;
    logic          wr_stb;
    logic [SW-1:0] wr_sel;
    logic [DW-1:0] wr_data;

    rtc_ser_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (ser_clk),
        .en        (ser_en),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .en_rise   (en_rise)
    );

    rtc_ser_frame #(.DW(DW), .AW(AW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .en_rise   (en_rise),
        .en        (ser_en),
        .din       (ser_din),
        .rd_data   (rd_data),
        .rd_sel    (rd_sel),
        .wr_stb    (wr_stb),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .dout      (ser_dout),
        .ready     (ser_ready)
    );

    rtc_ser_regs #(.DW(DW), .SW(SW), .GW(GW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .wr_stb    (wr_stb),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .seconds   (seconds_o),
        .gpo_word  (gpo_word_o)
    );
endmodule

// File: rtl/rtc_serial_port_chk.sv
// Property checker for the serial RTC register port, bound to the top.
// Assumes reset is held low for at least one clock edge at start-up.
module rtc_serial_port_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 3,
    parameter int unsigned GW = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_1hz,
    input logic          ser_ready,
    input logic          ser_dout,
    input logic [DW-1:0] seconds_o,
    input logic [GW-1:0] gpo_word_o,
    input logic          en_rise,
    input logic          sclk_fall,
    input logic          wr_stb,
    input logic [SW-1:0] wr_sel,
    input logic [DW-1:0] wr_data
);
    // R7
    sec_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !(wr_stb && wr_sel == '0)) |=> seconds_o == $past(seconds_o) + 1'b1);

    // R8
    sec_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == '0) |=> seconds_o == $past(wr_data));

    // R2
    start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ready && en_rise) |=> !ser_ready);

    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(ser_dout));

    // R9
    gpo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_sel == SW'(1)) |=> $stable(gpo_word_o));

    // R5
    commit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !ser_ready);
endmodule

bind rtc_serial_port rtc_serial_port_chk #(.DW(DW), .SW(SW), .GW(GW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .ser_ready  (ser_ready),
    .ser_dout   (ser_dout),
    .seconds_o  (seconds_o),
    .gpo_word_o (gpo_word_o),
    .en_rise    (en_rise),
    .sclk_fall  (sclk_fall),
    .wr_stb     (wr_stb),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data)
);

// File: tb/rtc_serial_port_tb_top.sv
// Bench for the serial RTC register port: a behavioural model runs every
// clock and is compared at each falling edge; directed checks add constants.
module rtc_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        ser_en = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic        ser_ready;
    logic [31:0] seconds_o;
    logic [24:0] gpo_word_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_serial_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1hz   (tick_1hz),
        .ser_en     (ser_en),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_dout   (ser_dout),
        .ser_ready  (ser_ready),
        .seconds_o  (seconds_o),
        .gpo_word_o (gpo_word_o)
    );

    // ---------------- reference model ----------------
    bit          m_prev_clk, m_prev_en, m_armed, m_dout;
    int          m_phase;              // 0 idle, 1 receiving, 2 sending
    bit          m_bits[$];
    logic [31:0] m_tx, m_sec;
    logic [24:0] m_gpo;
    int          m_nout;

    function automatic logic [31:0] m_slot(int sel);
        if (sel == 0) return m_sec;
        if (sel == 1) return {7'd0, m_gpo};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev_clk = 0; m_prev_en = 0; m_armed = 0; m_dout = 0;
            m_phase = 0; m_bits.delete(); m_tx = 0; m_sec = 0; m_gpo = 0; m_nout = 0;
        end else begin
            bit rise, fall, enr, w0, w1;
            logic [31:0] wd;
            rise = ser_clk && !m_prev_clk;
            fall = !ser_clk && m_prev_clk;
            enr  = ser_en && !m_prev_en;
            w0 = 0; w1 = 0; wd = 0;
            case (m_phase)
                0: if (enr) begin m_bits.delete(); m_phase = 1; end
                1: if (rise) begin
                    m_bits.push_back(ser_din);
                    if (!ser_en) begin
                        int n;
                        int sel;
                        n = m_bits.size();
                        m_phase = 0;
                        if (n >= 4) begin
                            sel = 4 * m_bits[n-4] + 2 * m_bits[n-3] + m_bits[n-2];
                            if (m_bits[n-1]) begin
                                if (n == 36) begin
                                    for (int i = 0; i < 32; i++) wd = {wd[30:0], m_bits[i]};
                                    w0 = (sel == 0); w1 = (sel == 1);
                                end
                            end else begin
                                m_tx = m_slot(sel); m_phase = 2; m_nout = 0; m_armed = 0;
                            end
                        end
                    end
                end
                default: begin
                    if (rise) m_armed = 1;
                    else if (fall && m_armed) begin
                        m_dout = m_tx[31]; m_tx = m_tx << 1; m_armed = 0; m_nout++;
                        if (m_nout == 32) m_phase = 0;
                    end
                end
            endcase
            if (w0) m_sec = wd;
            else if (tick_1hz) m_sec = m_sec + 1;
            if (w1) m_gpo = wd[24:0];
            m_prev_clk = ser_clk;
            m_prev_en  = ser_en;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (checking && !done) begin
            check("R2 ready", {31'd0, ser_ready}, {31'd0, m_phase == 0});
            check("R6 dout", {31'd0, ser_dout}, {31'd0, m_dout});
            check("R7 seconds", seconds_o, m_sec);
            check("R9 control word", {7'd0, gpo_word_o}, {7'd0, m_gpo});
        end
    end

    task automatic report();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            report();
        end
    end

    // ---------------- host tasks ----------------
    task automatic pulse(input logic d, input bit tick_on_rise = 0);
        @(negedge clk); ser_din = d; ser_clk = 1'b1; tick_1hz = tick_on_rise;
        @(negedge clk); ser_clk = 1'b0; tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_frame();
        while (!ser_ready) @(negedge clk);
        @(negedge clk); ser_en = 1'b1;
    endtask

    // Write with a chosen number of data bits (32 is a legal frame).
    task automatic write_reg(input int sel, input logic [31:0] data,
                             input int nd = 32, input bit tick_end = 0);
        logic [3:0] a;
        a = {sel[2:0], 1'b1};
        open_frame();
        for (int i = nd - 1; i >= 0; i--) pulse(data[i]);
        for (int i = 3; i >= 1; i--) pulse(a[i]);
        @(negedge clk); ser_en = 1'b0;
        pulse(a[0], tick_end);
    endtask

    task automatic read_reg(input int sel, output logic [31:0] val);
        logic [3:0] a;
        a = {sel[2:0], 1'b0};
        val = 0;
        open_frame();
        for (int i = 3; i >= 1; i--) pulse(a[i]);
        @(negedge clk); ser_en = 1'b0;
        pulse(a[0]);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0);
            val = {val[30:0], ser_dout};
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rv;
        idle(3);
        // R1: reset state
        check("R1 ready", {31'd0, ser_ready}, 32'd1);
        check("R1 dout", {31'd0, ser_dout}, 32'd0);
        check("R1 seconds", seconds_o, 32'd0);
        check("R1 control word", {7'd0, gpo_word_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        checking = 1'b1;
        idle(2);

        // R3 R5 R9: write the control word, upper bits dropped
        write_reg(1, 32'hFE5A_5A5A);
        idle(2);
        check("R5 ready after write", {31'd0, ser_ready}, 32'd1);
        check("R9 control word", {7'd0, gpo_word_o}, 32'h005A_5A5A);
        read_reg(1, rv);
        check("R9 read back", rv, 32'h005A_5A5A);

        // R5 R6: seconds write and read back MSB first
        write_reg(0, 32'd1000);
        idle(2);
        check("R5 seconds", seconds_o, 32'd1000);
        read_reg(0, rv);
        check("R6 read seconds", rv, 32'd1000);
        idle(2);
        check("R6 ready after read", {31'd0, ser_ready}, 32'd1);

        // R7: three ticks
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
        idle(1);
        check("R7 ticks", seconds_o, 32'd1003);

        // R8: tick in the commit cycle loses to the write
        write_reg(0, 32'hC0DE_0042, 32, 1);
        idle(2);
        check("R8 write wins", seconds_o, 32'hC0DE_0042);

        // R10: empty slot
        write_reg(5, 32'hFFFF_FFFF);
        idle(2);
        check("R10 seconds kept", seconds_o, 32'hC0DE_0042);
        check("R10 control kept", {7'd0, gpo_word_o}, 32'h005A_5A5A);
        read_reg(5, rv);
        check("R10 empty read", rv, 32'd0);

        // R11: 3-bit frame discarded
        open_frame();
        pulse(1'b0); pulse(1'b0);
        @(negedge clk); ser_en = 1'b0;
        pulse(1'b1);
        idle(2);
        check("R11 ready", {31'd0, ser_ready}, 32'd1);
        check("R11 seconds kept", seconds_o, 32'hC0DE_0042);

        // R12: 35-bit write frame discarded
        write_reg(0, 32'h1234_5678, 31);
        idle(2);
        check("R12 seconds kept", seconds_o, 32'hC0DE_0042);

        // R4: enable held high past four bits keeps the frame open
        open_frame();
        for (int i = 0; i < 4; i++) pulse(1'b0);
        check("R4 still open", {31'd0, ser_ready}, 32'd0);
        @(negedge clk); ser_en = 1'b0;
        pulse(1'b1);
        idle(2);
        check("R4 closed", {31'd0, ser_ready}, 32'd1);
        check("R4 seconds kept", seconds_o, 32'hC0DE_0042);

        // R6: read of control word after a different pattern
        write_reg(1, 32'h0135_7ACE);
        read_reg(1, rv);
        check("R6 read pattern", rv, 32'h0135_7ACE);

        idle(4);
        report();
    end
endmodule